// File: doc/BRIEF.md
# Byte-Word Data Memory Access Unit

This unit connects a 16-bit processor datapath to a data RAM built as two byte-wide lanes, a low lane and a high lane, that share one word-index decode. Each request carries a 16-bit byte address, a byte-or-word size flag, a read-or-write flag and 16-bit write data. The unit picks the lanes that a write touches, moves a selected byte onto the low bits of the read data, and blanks the read data for locations that hold no memory. The low lane holds even addresses and the high lane holds odd addresses.

A word access at an odd address is a misalignment fault. A faulting write changes no memory. A faulting read still returns the word that contains the address. In both cases the unit raises a one-cycle address-trap pulse together with the response. The upper half of the address space, where address bit 15 is set, has no memory behind it: reads return zero, writes are dropped and no trap is raised. In the lower half, memory exists only below `IMPL_BYTES`.

Requests and responses use valid/ready handshakes. A request is accepted on a cycle where `req_valid` and `req_ready` are both high. Its response appears the next cycle in a single response slot. While `rsp_valid` is high and `rsp_ready` is low, the slot holds its contents and `req_ready` stays low. The slot frees, and a new request can be accepted, in the same cycle that the consumer takes the response.

Top module: `dmem_access_unit`

## Requirements
- R1: A byte read at address A returns the byte stored at A on bits [7:0], with bits [15:8] at zero. An even A selects the low lane and an odd A selects the high lane.
- R2: A word read at an even address A returns the byte at A+1 on bits [15:8] and the byte at A on bits [7:0].
- R3: A byte write at address A writes write-data bits [7:0] into the lane that A[0] selects. The other lane of that word keeps its value.
- R4: A word write at an even in-range address writes write-data bits [7:0] to the low lane and bits [15:8] to the high lane.
- R5: A word access with A[0]=1 and A[15]=0 drives `addr_trap` high for exactly the first cycle of its response. No other access raises `addr_trap`.
- R6: A misaligned word write changes no memory.
- R7: A misaligned word read returns the word at A with bit 0 cleared, laid out as in R2, provided that word is in range.
- R8: With A[15]=0 and A at or above `IMPL_BYTES`, a read returns zero and a write is dropped. A dropped write leaves every implemented location unchanged, so it does not alias onto one.
- R9: With A[15]=1, a read returns zero, a write is dropped, and no trap is raised, even for a misaligned word.
- R10: The response of an accepted request is valid on the next cycle. Write responses carry zero data. While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid` and `rsp_rdata` hold and `req_ready` is low.
- R11: During reset, `rsp_valid` and `addr_trap` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | ADDR_W (16) | Byte address |
| req_wdata | input | 2*LANE_W (16) | Write data; a byte write uses bits [7:0] |
| rsp_valid | output | 1 | Response slot holds a response |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 2*LANE_W (16) | Read data; zero for writes |
| addr_trap | output | 1 | Misalignment trap pulse, aligned with the response |

## Verification
The bench writes known word patterns to every even address and reads them back as words, which checks lane order. It then writes bytes to every third address and reads every byte and every word, which shows whether the untouched lane of each word kept its value. Word accesses at each odd address check the trap, the dropped write and the data returned by a misaligned read. Accesses at and beyond the implemented boundary and in the upper half check the zero read and show whether a dropped write aliases onto low memory. A stalled response checks that the data holds, that the trap lasts one cycle, and that a request waiting behind the stall is accepted only once the slot frees.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

  // Per-response control carried from acceptance to the read-data steering.
  typedef struct packed {
    logic is_read;   // request was a read
    logic is_word;   // request was a word access
    logic byte_hi;   // address bit 0: selects the high lane for a byte
    logic hit;       // address maps to implemented memory
  } rsp_ctl_t;

endpackage

// File: rtl/dmem_addr_check.sv
module dmem_addr_check #(
  parameter int ADDR_W     = 16,
  parameter int IMPL_WORDS = 1024,
  parameter int IDX_W      = 10
) (
  input  logic              req_fire,
  input  logic              req_write,
  input  logic              req_word,
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic              hit,
  output logic              trap_req,
  output logic              we_lo,
  output logic              we_hi
);
  localparam int WNUM_W = ADDR_W - 2;

  logic              top_half;
  logic [WNUM_W-1:0] word_num;
  logic              misalign;
  logic              wr_ok;

  always_comb begin
    top_half = addr[ADDR_W-1];
    word_num = addr[ADDR_W-2:1];
    // Widen by one bit so a full lower half still compares correctly.
    hit      = !top_half && ({1'b0, word_num} < (WNUM_W+1)'(IMPL_WORDS));
    misalign = req_word && addr[0];
    trap_req = misalign && !top_half;
    wr_ok    = req_fire && req_write && hit && !misalign;
    we_lo    = wr_ok && (req_word || !addr[0]);
    we_hi    = wr_ok && (req_word || addr[0]);
    word_idx = word_num[IDX_W-1:0];
  end

endmodule

// File: rtl/dmem_lane_ram.sv
module dmem_lane_ram #(
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= mem[idx];
  end

endmodule

// File: rtl/dmem_read_align.sv
module dmem_read_align import dmem_pkg::*; #(
  parameter int LANE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                valid,
  input  rsp_ctl_t            ctl,
  input  logic [LANE_W-1:0]   lo,
  input  logic [LANE_W-1:0]   hi,
  output logic [2*LANE_W-1:0] data
);
  always_comb begin
    if (!ctl.is_read || !ctl.hit) data = '0;
    else if (ctl.is_word)         data = {hi, lo};
    else                          data = {{LANE_W{1'b0}}, (ctl.byte_hi ? hi : lo)};
  end

  // R1: a byte response never carries anything in the upper lane position
  p_byte_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ctl.is_word) |-> (data[2*LANE_W-1:LANE_W] == '0));

endmodule

// File: rtl/dmem_access_unit.sv
module dmem_access_unit import dmem_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int LANE_W     = 8,
  parameter int IMPL_BYTES = 2048
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic                req_word,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                rsp_valid,
  input  logic                rsp_ready,
  output logic [2*LANE_W-1:0] rsp_rdata,
  output logic                addr_trap
);
  localparam int IMPL_WORDS = IMPL_BYTES / 2;
  localparam int IDX_W      = (IMPL_WORDS > 1) ? $clog2(IMPL_WORDS) : 1;
  localparam int NLANES     = 2;

  logic              acc;
  logic [IDX_W-1:0]  word_idx;
  logic              hit, trap_req, we_lo, we_hi;
  logic              lane_we [NLANES];
  logic [LANE_W-1:0] lane_wd [NLANES];
  logic [LANE_W-1:0] lane_rd [NLANES];
  logic              rsp_valid_q, trap_q;
  rsp_ctl_t          ctl_q;

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;

  dmem_addr_check #(
    .ADDR_W(ADDR_W), .IMPL_WORDS(IMPL_WORDS), .IDX_W(IDX_W)
  ) u_check (
    .req_fire (acc),
    .req_write(req_write),
    .req_word (req_word),
    .addr     (req_addr),
    .word_idx (word_idx),
    .hit      (hit),
    .trap_req (trap_req),
    .we_lo    (we_lo),
    .we_hi    (we_hi)
  );

  // Lane 0 holds even addresses, lane 1 odd. A byte write always uses the
  // low data byte; a word write splits the data across both lanes.
  assign lane_we[0] = we_lo;
  assign lane_we[1] = we_hi;
  assign lane_wd[0] = req_wdata[LANE_W-1:0];
  assign lane_wd[1] = req_word ? req_wdata[2*LANE_W-1:LANE_W] : req_wdata[LANE_W-1:0];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    dmem_lane_ram #(
      .DEPTH(IMPL_WORDS), .IDX_W(IDX_W), .LANE_W(LANE_W)
    ) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .rd_en(acc),
      .we   (lane_we[g]),
      .idx  (word_idx),
      .wdata(lane_wd[g]),
      .rdata(lane_rd[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      trap_q      <= 1'b0;
      ctl_q       <= '0;
    end else if (acc) begin
      rsp_valid_q   <= 1'b1;
      trap_q        <= trap_req;
      ctl_q.is_read <= !req_write;
      ctl_q.is_word <= req_word;
      ctl_q.byte_hi <= req_addr[0];
      ctl_q.hit     <= hit;
    end else begin
      trap_q <= 1'b0;
      if (rsp_ready) rsp_valid_q <= 1'b0;
    end
  end

  dmem_read_align #(.LANE_W(LANE_W)) u_align (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(rsp_valid_q),
    .ctl  (ctl_q),
    .lo   (lane_rd[0]),
    .hi   (lane_rd[1]),
    .data (rsp_rdata)
  );

  assign rsp_valid = rsp_valid_q;
  assign addr_trap = trap_q;

  // R3: a byte request never enables both lanes
  p_byte_single_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_word) |-> !(lane_we[0] && lane_we[1]));

  // R4: an aligned in-range word write enables both lanes
  p_word_both_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_word && !req_addr[0] && hit) |-> (lane_we[0] && lane_we[1]));

  // R6: a misaligned word request leaves both lanes untouched
  p_misalign_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && req_addr[0]) |-> !(lane_we[0] || lane_we[1]));

  // R5: the trap only rides on a freshly accepted response
  p_trap_with_rsp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_trap |-> (rsp_valid && $past(acc)));

  // R9: the upper half never traps
  p_upper_no_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_addr[ADDR_W-1]) |=> !addr_trap);

  // R10: response follows acceptance by one cycle
  p_rsp_after_acc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);

  // R10: a stalled response holds its data
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  // R10: no acceptance while the slot is full and stalled
  p_no_acc_when_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

endmodule

// File: tb/dmem_access_unit_tb.sv
`timescale 1ns/1ps
module dmem_access_unit_tb;
  localparam int IMPL = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b1;
  logic        req_ready, rsp_valid, addr_trap;
  logic [15:0] rsp_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] m [IMPL];

  always #2 clk = ~clk;

  dmem_access_unit #(.ADDR_W(16), .LANE_W(8), .IMPL_BYTES(IMPL)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_word(req_word), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .addr_trap(addr_trap)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit in_range(logic [15:0] ea);
    return !ea[15] && (int'(ea) < IMPL);
  endfunction

  function automatic logic [15:0] model_read(bit wd, logic [15:0] ea);
    int b;
    if (!in_range(ea)) return 16'h0;
    b = int'(ea);
    if (wd) return {m[b | 1], m[b & ~1]};
    return {8'h00, m[b]};
  endfunction

  task automatic model_write(bit wd, logic [15:0] ea, logic [15:0] d);
    int b;
    if (!in_range(ea) || (wd && ea[0])) return;
    b = int'(ea);
    if (wd) begin m[b] = d[7:0]; m[b + 1] = d[15:8]; end
    else m[b] = d[7:0];
  endtask

  task automatic op(input bit wr, input bit wd, input logic [15:0] ea,
                    input logic [15:0] wdat, input string tag);
    logic [15:0] exp_d;
    bit          exp_t;
    exp_d = wr ? 16'h0 : model_read(wd, ea);
    exp_t = wd && ea[0] && !ea[15];
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = ea; req_wdata = wdat;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, tag, "rsp_valid", {15'b0, rsp_valid}, 16'h1);
    check(rsp_rdata === exp_d, tag, "rdata", rsp_rdata, exp_d);
    check(addr_trap === exp_t, tag, "trap", {15'b0, addr_trap}, {15'b0, exp_t});
    if (wr) model_write(wd, ea, wdat);
  endtask

  function automatic logic [15:0] pat_w(int a);
    return 16'((a * 16'h1357) ^ 16'hC3A5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] held;
    // R11: reset state
    repeat (2) @(negedge clk);
    check(rsp_valid === 1'b0, "R11", "rsp_valid", {15'b0, rsp_valid}, 16'h0);
    check(addr_trap === 1'b0, "R11", "trap", {15'b0, addr_trap}, 16'h0);
    check(req_ready === 1'b1, "R11", "req_ready", {15'b0, req_ready}, 16'h1);
    rst_n = 1'b1;

    // R4 / R2: fill with words, read them back as words
    for (int a = 0; a < IMPL; a += 2) op(1'b1, 1'b1, 16'(a), pat_w(a), "R4");
    for (int a = 0; a < IMPL; a += 2) op(1'b0, 1'b1, 16'(a), 16'h0, "R2");

    // R3 / R1: byte writes to every third address, upper data byte is noise
    for (int a = 0; a < IMPL; a += 3)
      op(1'b1, 1'b0, 16'(a), {8'hEE, 8'(a * 7 + 8'h31)}, "R3");
    for (int a = 0; a < IMPL; a++) op(1'b0, 1'b0, 16'(a), 16'h0, "R1");
    for (int a = 0; a < IMPL; a += 2) op(1'b0, 1'b1, 16'(a), 16'h0, "R3");

    // R5 / R6 / R7: misaligned word writes and reads
    for (int a = 1; a < IMPL; a += 2) begin
      op(1'b1, 1'b1, 16'(a), 16'hDEAD, "R6");
      op(1'b0, 1'b1, 16'(a), 16'h0, "R7");
      op(1'b0, 1'b1, 16'(a - 1), 16'h0, "R6");
    end

    // R8: lower half beyond the implemented size
    op(1'b1, 1'b1, 16'(IMPL), 16'h1234, "R8");
    op(1'b1, 1'b0, 16'(IMPL + 1), 16'h0055, "R8");
    op(1'b1, 1'b1, 16'h0400, 16'hBEEF, "R8");
    op(1'b1, 1'b1, 16'h7FFE, 16'hCAFE, "R8");
    op(1'b1, 1'b0, 16'h7FFF, 16'h0077, "R8");
    op(1'b0, 1'b1, 16'(IMPL), 16'h0, "R8");
    op(1'b0, 1'b0, 16'(IMPL + 1), 16'h0, "R8");
    op(1'b0, 1'b1, 16'h0400, 16'h0, "R8");
    op(1'b0, 1'b1, 16'h7FFE, 16'h0, "R8");
    op(1'b0, 1'b1, 16'(IMPL + 1), 16'h0, "R5");
    op(1'b0, 1'b0, 16'(IMPL - 1), 16'h0, "R8");

    // R9: upper half
    op(1'b1, 1'b1, 16'h8000, 16'h4321, "R9");
    op(1'b1, 1'b1, 16'h8001, 16'h4321, "R9");
    op(1'b1, 1'b0, 16'hFFFF, 16'h00AA, "R9");
    op(1'b0, 1'b1, 16'h8000, 16'h0, "R9");
    op(1'b0, 1'b1, 16'h8001, 16'h0, "R9");
    op(1'b0, 1'b0, 16'hFFFF, 16'h0, "R9");
    op(1'b0, 1'b1, 16'hFFFE, 16'h0, "R9");

    // R8 / R9: no aliasing onto implemented memory
    for (int a = 0; a < IMPL; a += 2) op(1'b0, 1'b1, 16'(a), 16'h0, "R8");

    // R10: write responses carry zero data
    op(1'b1, 1'b0, 16'h0005, 16'hFF5A, "R10");

    // R10 / R5: stalled response, held data, one-cycle trap, queued request
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_word = 1'b1; req_addr = 16'h0003;
    @(negedge clk);
    req_addr = 16'h0004;
    held = model_read(1'b1, 16'h0003);
    check(rsp_valid === 1'b1, "R10", "stall valid", {15'b0, rsp_valid}, 16'h1);
    check(rsp_rdata === held, "R7", "stall data", rsp_rdata, held);
    check(addr_trap === 1'b1, "R5", "trap first cycle", {15'b0, addr_trap}, 16'h1);
    check(req_ready === 1'b0, "R10", "ready while full", {15'b0, req_ready}, 16'h0);
    @(negedge clk);
    check(rsp_valid === 1'b1, "R10", "still valid", {15'b0, rsp_valid}, 16'h1);
    check(rsp_rdata === held, "R10", "held data", rsp_rdata, held);
    check(addr_trap === 1'b0, "R5", "trap second cycle", {15'b0, addr_trap}, 16'h0);
    check(req_ready === 1'b0, "R10", "ready still low", {15'b0, req_ready}, 16'h0);
    @(negedge clk);
    check(rsp_rdata === held, "R10", "held data 2", rsp_rdata, held);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1, "R10", "queued valid", {15'b0, rsp_valid}, 16'h1);
    check(rsp_rdata === model_read(1'b1, 16'h0004), "R10", "queued data",
          rsp_rdata, model_read(1'b1, 16'h0004));
    check(addr_trap === 1'b0, "R5", "aligned no trap", {15'b0, addr_trap}, 16'h0);
    @(negedge clk);
    check(rsp_valid === 1'b0, "R10", "slot drained", {15'b0, rsp_valid}, 16'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule